// File: doc/BRIEF.md
# Controller Byte FIFO with Command Capture

This block is the byte-wide FIFO register of a storage-bus controller, as software sees it. Bytes written through the FIFO port go into a small data buffer with a read pointer, a write pointer and a signed count of pending bytes. Reads take bytes from the same buffer in arrival order. When the buffer has been read empty, both pointers go back to zero, so the full capacity can be used again.

While the command-capture input is high, written bytes bypass the data buffer. They are appended to a separate, bounded command buffer, which a neighbouring engine reads by index. Two further inputs act on the FIFO itself. A status-response load places a two-byte reply (the status byte, then zero) in the buffer. A flush command resets the flags, sequence-step and interrupt registers. A direction input marks the data-out phase, in which FIFO reads return zero.

The write side is valid/ready. A byte is accepted on a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` drops only while a read request or a status load is present in the same cycle, because those operations take priority. An accepted byte that finds no room is counted as an overrun rather than stalled. Reads are single-cycle requests, and each is answered one cycle later by a response pulse.

Top module: `scsi_fifo_port`

## Requirements
- R1: A write accepted with command capture low stores `wr_data` at the tail of the data buffer and raises `pend_size` by one. `wr_ready` is low exactly in cycles where `rd_req` or `status_load` is high.
- R2: When the buffer already holds DEPTH-1 bytes (15 by default), an accepted write is dropped. In that case `pend_size` is unchanged and `data_ovr` is high for the one cycle after the write.
- R3: While `cmd_mode` is high, an accepted write is appended to the command buffer at index `cmd_len`, and `cmd_len` rises by one. The data buffer and `pend_size` are unchanged.
- R4: When `cmd_len` equals CMD_DEPTH (32 by default), a command write is dropped. `cmd_len` and the stored bytes stay the same, and `cmd_ovr` is high for the one cycle after the write.
- R5: A read request with `dir_out` low and bytes pending returns the oldest byte on `rd_rsp_data`. The byte appears in the cycle after the request, together with `rd_rsp_valid`, and `pend_size` falls by one.
- R6: A read request while `dir_out` is high returns 0x00 and consumes no byte, so `pend_size` is unchanged.
- R7: A read request with nothing pending returns the same byte that the previous read returned. `pend_size` stays 0.
- R8: Once a read empties the buffer, both pointers restart at zero. The next DEPTH-1 writes are then all accepted without overrun.
- R9: `status_load` replaces the buffer contents with `status_byte` followed by 0x00. `pend_size` becomes 2 and `fifo_flags` becomes 2, and the next two reads return the status byte and then 0x00.
- R10: `flush` sets `fifo_flags` to 0, `seq_step` to 0 and `intr_code` to 0x08 (bit 3, function complete). `pend_size` does not change. If `flush` and `status_load` occur in the same cycle, the flush wins for `fifo_flags`.
- R11: After reset, `pend_size`, `fifo_flags`, `seq_step`, `intr_code`, `cmd_len`, `rd_rsp_valid`, `data_ovr` and `cmd_ovr` are all zero, and `wr_ready` is high when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | FIFO write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_data | input | 8 | Byte to write |
| rd_req | input | 1 | FIFO read request (one cycle) |
| rd_rsp_valid | output | 1 | Read response, one cycle after `rd_req` |
| rd_rsp_data | output | 8 | Byte returned by the read |
| cmd_mode | input | 1 | Send writes to the command buffer |
| dir_out | input | 1 | Transfer phase is data-out |
| flush | input | 1 | Flush command pulse |
| status_load | input | 1 | Load the two-byte status response |
| status_byte | input | 8 | Status byte for the response |
| pend_size | output | 5 | Signed count of pending bytes |
| fifo_flags | output | 5 | FIFO-flags register |
| seq_step | output | 3 | Sequence-step register |
| intr_code | output | 8 | Interrupt register |
| data_ovr | output | 1 | Data buffer overrun pulse |
| cmd_len | output | 6 | Command bytes captured |
| cmd_ovr | output | 1 | Command buffer overrun pulse |
| cmd_rd_idx | input | 5 | Command buffer read index |
| cmd_rd_data | output | 8 | Command byte at `cmd_rd_idx` |

## Verification
Every result except `wr_ready` and `cmd_rd_data` comes from a register. A strobe driven before a rising edge therefore shows its effect exactly one edge later. This includes the read response, the pending count, the overrun pulses and the control registers. The bench drives on the falling edge and samples on the next falling edge, so it always looks at the state one edge after the stimulus. Read results go through a queue of expected bytes, and a monitor compares each byte on the falling edge where `rd_rsp_valid` is seen. The two combinational outputs are checked in the same half-cycle as the inputs that drive them.

// File: rtl/scsi_fifo_pkg.sv
package scsi_fifo_pkg;
  localparam int          FLAG_W         = 5;
  localparam int          SEQ_W          = 3;
  localparam logic [7:0]  INTR_FUNC_DONE = 8'h08;
  localparam int          RESP_LEN       = 2;
endpackage

// File: rtl/sfifo_data.sv
module sfifo_data #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             rd_en,
  input  logic             dir_out,
  input  logic             preload,
  input  logic [7:0]       preload_byte,
  output logic [7:0]       hold_byte,
  output logic [CNT_W-1:0] pend,
  output logic             ovr
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rptr, wptr, rptr_n, wptr_n;
  logic [CNT_W-1:0] pend_n;
  logic [7:0]       hold_n;
  logic             ovr_n, full, do_wr;

  assign full  = (wptr == PTR_W'(DEPTH - 1));
  assign do_wr = wr_en && !rd_en && !preload && !full;

  always_comb begin
    rptr_n = rptr;
    wptr_n = wptr;
    pend_n = pend;
    hold_n = hold_byte;
    ovr_n  = 1'b0;
    if (preload) begin
      rptr_n = '0;
      wptr_n = PTR_W'(scsi_fifo_pkg::RESP_LEN);
      pend_n = CNT_W'(scsi_fifo_pkg::RESP_LEN);
    end else if (rd_en) begin
      if (dir_out) begin
        hold_n = 8'h00;
      end else if (rptr < wptr) begin
        hold_n = mem[rptr];
        rptr_n = rptr + 1'b1;
        pend_n = pend - 1'b1;
      end
      if (rptr_n == wptr_n) begin
        rptr_n = '0;
        wptr_n = '0;
      end
    end else if (wr_en) begin
      if (full) begin
        ovr_n = 1'b1;
      end else begin
        wptr_n = wptr + 1'b1;
        pend_n = pend + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr      <= '0;
      wptr      <= '0;
      pend      <= '0;
      hold_byte <= '0;
      ovr       <= 1'b0;
    end else begin
      rptr      <= rptr_n;
      wptr      <= wptr_n;
      pend      <= pend_n;
      hold_byte <= hold_n;
      ovr       <= ovr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (preload) begin
      mem[0] <= preload_byte;
      mem[1] <= 8'h00;
    end else if (do_wr) begin
      mem[wptr] <= wr_byte;
    end
  end

  // R2
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[CNT_W-1] && (pend <= CNT_W'(DEPTH - 1)));
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !preload && full) |=> (ovr && $stable(pend)));
  // R5
  rd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !preload && !dir_out && pend != '0) |=> (pend == $past(pend) - 1'b1));
  // R6
  rd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !preload && dir_out) |=> (hold_byte == 8'h00 && $stable(pend)));
endmodule

// File: rtl/sfifo_cmd.sv
module sfifo_cmd #(
  parameter int CMD_DEPTH = 32,
  localparam int IDX_W = $clog2(CMD_DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [LEN_W-1:0] len,
  output logic             ovr
);
  logic [7:0] mem [CMD_DEPTH];
  logic       room;

  assign room    = (len < LEN_W'(CMD_DEPTH));
  assign rd_byte = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0;
      ovr <= 1'b0;
    end else begin
      ovr <= wr_en && !room;
      if (wr_en && room) len <= len + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && room) mem[len[IDX_W-1:0]] <= wr_byte;
  end

  // R4
  cmd_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_W'(CMD_DEPTH));
  // R3
  cmd_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && room) |=> (len == $past(len) + 1'b1 && !ovr));
  // R4
  cmd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !room) |=> (ovr && $stable(len)));
endmodule

// File: rtl/sfifo_ctl.sv
module sfifo_ctl
  import scsi_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              preload,
  output logic [FLAG_W-1:0] flags,
  output logic [SEQ_W-1:0]  seq,
  output logic [7:0]        intr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      seq   <= '0;
      intr  <= '0;
    end else if (flush) begin
      flags <= '0;
      seq   <= '0;
      intr  <= INTR_FUNC_DONE;
    end else if (preload) begin
      flags <= FLAG_W'(RESP_LEN);
    end
  end

  // R10
  flush_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (intr == INTR_FUNC_DONE && flags == '0 && seq == '0));
  // R9
  resp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !flush) |=> (flags == FLAG_W'(RESP_LEN)));
endmodule

// File: rtl/scsi_fifo_port.sv
module scsi_fifo_port #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = $clog2(CMD_DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic [7:0]                       wr_data,
  input  logic                             rd_req,
  output logic                             rd_rsp_valid,
  output logic [7:0]                       rd_rsp_data,
  input  logic                             cmd_mode,
  input  logic                             dir_out,
  input  logic                             flush,
  input  logic                             status_load,
  input  logic [7:0]                       status_byte,
  output logic signed [CNT_W-1:0]          pend_size,
  output logic [scsi_fifo_pkg::FLAG_W-1:0] fifo_flags,
  output logic [scsi_fifo_pkg::SEQ_W-1:0]  seq_step,
  output logic [7:0]                       intr_code,
  output logic                             data_ovr,
  output logic [LEN_W-1:0]                 cmd_len,
  output logic                             cmd_ovr,
  input  logic [IDX_W-1:0]                 cmd_rd_idx,
  output logic [7:0]                       cmd_rd_data
);
  logic             wr_acc;
  logic [CNT_W-1:0] pend_raw;

  assign wr_ready  = !rd_req && !status_load;
  assign wr_acc    = wr_valid && wr_ready;
  assign pend_size = $signed(pend_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_rsp_valid <= 1'b0;
    else        rd_rsp_valid <= rd_req;
  end

  sfifo_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_acc && !cmd_mode), .wr_byte(wr_data),
    .rd_en(rd_req), .dir_out(dir_out),
    .preload(status_load), .preload_byte(status_byte),
    .hold_byte(rd_rsp_data), .pend(pend_raw), .ovr(data_ovr)
  );

  sfifo_cmd #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_acc && cmd_mode), .wr_byte(wr_data),
    .rd_idx(cmd_rd_idx), .rd_byte(cmd_rd_data),
    .len(cmd_len), .ovr(cmd_ovr)
  );

  sfifo_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .flush(flush), .preload(status_load),
    .flags(fifo_flags), .seq(seq_step), .intr(intr_code)
  );

  // R5
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_rsp_valid);
  // R3
  cmd_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cmd_mode && !rd_req && !status_load) |=> $stable(pend_size));
endmodule

// File: tb/scsi_fifo_port_tb_top.sv
module scsi_fifo_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, rd_req = 0, cmd_mode = 0, dir_out = 0, flush = 0, status_load = 0;
  logic [7:0] wr_data = 0, status_byte = 0;
  logic [4:0] cmd_rd_idx = 0;
  logic wr_ready, rd_rsp_valid, data_ovr, cmd_ovr;
  logic [7:0] rd_rsp_data, intr_code, cmd_rd_data;
  logic signed [4:0] pend_size;
  logic [4:0] fifo_flags;
  logic [2:0] seq_step;
  logic [5:0] cmd_len;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  scsi_fifo_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_req(rd_req), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cmd_mode(cmd_mode), .dir_out(dir_out), .flush(flush), .status_load(status_load),
    .status_byte(status_byte), .pend_size(pend_size), .fifo_flags(fifo_flags),
    .seq_step(seq_step), .intr_code(intr_code), .data_ovr(data_ovr), .cmd_len(cmd_len),
    .cmd_ovr(cmd_ovr), .cmd_rd_idx(cmd_rd_idx), .cmd_rd_data(cmd_rd_data)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected response", 1, 0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(rd_rsp_data == e, r, rd_rsp_data, e);
      end
    end
  end

  task automatic wr(logic [7:0] b);
    wr_valid = 1; wr_data = b;
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(logic [7:0] e, string r);
    exp_q.push_back(e); req_q.push_back(r);
    rd_req = 1;
    @(posedge clk); @(negedge clk);
    rd_req = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(pend_size == 0 && fifo_flags == 0 && seq_step == 0, "R11 pend/flags/seq", pend_size, 0);
    chk(intr_code == 0 && cmd_len == 0, "R11 intr/cmd_len", intr_code, 0);
    chk(!rd_rsp_valid && !data_ovr && !cmd_ovr && wr_ready, "R11 strobes", rd_rsp_valid, 0);

    // R1 writes and ready rule
    wr(8'hA1); wr(8'hB2); wr(8'hC3);
    chk(pend_size == 3, "R1 pend after 3 writes", pend_size, 3);
    rd_req = 1; #1;
    chk(wr_ready == 0, "R1 ready low during read", wr_ready, 0);
    rd_req = 0; #1;
    chk(wr_ready == 1, "R1 ready high idle", wr_ready, 1);

    // R5 FIFO order
    rd(8'hA1, "R5 byte0"); rd(8'hB2, "R5 byte1"); rd(8'hC3, "R5 byte2");
    chk(pend_size == 0, "R5 pend drained", pend_size, 0);
    // R7 empty read repeats last byte
    rd(8'hC3, "R7 empty read");
    chk(pend_size == 0, "R7 pend stays 0", pend_size, 0);

    // R8 snap-back: 15 writes accepted
    for (int i = 0; i < 15; i++) begin
      wr(8'(i * 7 + 1));
      chk(!data_ovr, "R8 no overrun after drain", data_ovr, 0);
    end
    chk(pend_size == 15, "R8 full capacity", pend_size, 15);

    // R2 overrun
    wr(8'hEE);
    chk(data_ovr == 1, "R2 overrun pulse", data_ovr, 1);
    chk(pend_size == 15, "R2 pend unchanged", pend_size, 15);
    @(posedge clk); @(negedge clk);
    chk(data_ovr == 0, "R2 pulse one cycle", data_ovr, 0);

    // R6 data-out read returns zero
    dir_out = 1;
    rd(8'h00, "R6 data-out read");
    chk(pend_size == 15, "R6 pend unchanged", pend_size, 15);
    dir_out = 0;
    for (int i = 0; i < 15; i++) rd(8'(i * 7 + 1), "R5 full drain order");
    chk(pend_size == 0, "R5 drained", pend_size, 0);

    // R3 command capture
    cmd_mode = 1;
    for (int i = 0; i < 32; i++) wr(8'(8'h40 + i));
    chk(cmd_len == 32, "R3 cmd_len", cmd_len, 32);
    chk(pend_size == 0, "R3 data untouched", pend_size, 0);
    cmd_rd_idx = 0; #1;
    chk(cmd_rd_data == 8'h40, "R3 cmd byte 0", cmd_rd_data, 8'h40);
    cmd_rd_idx = 31; #1;
    chk(cmd_rd_data == 8'h5F, "R3 cmd byte 31", cmd_rd_data, 8'h5F);
    // R4 command overrun
    wr(8'hFF);
    chk(cmd_ovr == 1 && cmd_len == 32, "R4 cmd overrun", cmd_len, 32);
    chk(cmd_rd_data == 8'h5F, "R4 last byte kept", cmd_rd_data, 8'h5F);
    cmd_mode = 0;

    // R9 status response
    status_byte = 8'h5A; status_load = 1;
    @(posedge clk); @(negedge clk);
    status_load = 0;
    chk(pend_size == 2, "R9 pend 2", pend_size, 2);
    chk(fifo_flags == 2, "R9 flags 2", fifo_flags, 2);
    rd(8'h5A, "R9 status byte"); rd(8'h00, "R9 zero byte");
    chk(pend_size == 0, "R9 drained", pend_size, 0);

    // R10 flush
    status_byte = 8'h02; status_load = 1;
    @(posedge clk); @(negedge clk);
    status_load = 0;
    flush = 1;
    @(posedge clk); @(negedge clk);
    flush = 0;
    chk(fifo_flags == 0 && seq_step == 0, "R10 flags/seq cleared", fifo_flags, 0);
    chk(intr_code == 8'h08, "R10 intr function done", intr_code, 8'h08);
    chk(pend_size == 2, "R10 pend untouched", pend_size, 2);

    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule